// File: doc/BRIEF.md
# Dual-trigger exposure timing controller

This block sets the exposure and readout timing for a line-scan sensor. Two trigger lines control it. A qualified rising edge on the start line opens an integration window after a fixed latency. A qualified rising edge on the stop line closes the window after a different fixed latency. Each closed window is followed by a readout phase that begins a fixed number of cycles later and lasts a set number of cycles. The next window can open while the previous frame is still being read out.

Both trigger lines are captured on the falling clock edge. Several controllers that share one clock and one set of trigger wires therefore take the same edge decision in the same cycle. A trigger counts only after it has stayed high for a minimum number of cycles, and shorter pulses are reported. The window is never shorter than a minimum length: a stop that comes too early is held back and reported. A window that closes while the previous readout is still waiting or running is reported as an overrun and gets no readout of its own. All delays and lengths are parameters counted in clock cycles.

Top module: `exposure_timing_ctrl`

## Requirements
- R1: When idle, a start pulse whose first high sample is at falling edge N raises `integrate_o` on rising edge N + MIN_PULSE + START_DLY + 2, counting rising edges after N.
- R2: While integrating, a stop pulse whose first high sample is at falling edge M lowers `integrate_o` on rising edge M + MIN_PULSE + STOP_DLY + 2. This holds when the window is then at least MIN_EXP cycles long.
- R3: If that stop would give a window shorter than MIN_EXP cycles, `integrate_o` stays high for exactly MIN_EXP cycles and `err_min_exp_o` pulses once, for one cycle, while the window is still open. A stop that gives exactly MIN_EXP cycles raises no error.
- R4: A trigger pulse sampled high on fewer than MIN_PULSE consecutive falling edges is discarded and pulses its error output (`err_short_start_o` or `err_short_stop_o`) for one cycle. A pulse sampled high on exactly MIN_PULSE edges is accepted.
- R5: A qualified stop while no window is open changes no output and raises no error.
- R6: `ro_start_o` pulses for one cycle exactly RO_DLY cycles after `integrate_o` falls. `ro_active_o` rises in the same cycle and stays high for exactly RO_LEN cycles.
- R7: A start trigger is accepted while `ro_active_o` is high, so the next window opens during the previous readout.
- R8: A window that closes while a readout is waiting or active pulses `err_overrun_o` for one cycle. That window is dropped and gets no `ro_start_o`.
- R9: While `rst_ni` is low, every output is low.
- R10: A start trigger that qualifies while a window is open or about to open is ignored and does not reopen or extend the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; triggers sampled on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_start_i | input | 1 | Trigger that opens the integration window |
| trig_stop_i | input | 1 | Trigger that closes the integration window |
| integrate_o | output | 1 | High while the integration window is open |
| ro_start_o | output | 1 | One-cycle pulse at the start of a readout |
| ro_active_o | output | 1 | High during the readout phase |
| err_short_start_o | output | 1 | Pulse: start trigger shorter than MIN_PULSE |
| err_short_stop_o | output | 1 | Pulse: stop trigger shorter than MIN_PULSE |
| err_min_exp_o | output | 1 | Pulse: stop held back to enforce MIN_EXP |
| err_overrun_o | output | 1 | Pulse: window closed during a pending or active readout |

## Verification
The bench covers the following edge cases and the failure each one would expose:
- **Pulse width at the threshold.** Pulses of MIN_PULSE and MIN_PULSE-1 samples are applied. An off-by-one in the qualifier would either accept the short pulse or reject the exact one.
- **Stop at the minimum-exposure limit.** The stop is placed so the natural close lands exactly on MIN_EXP, and also one cycle early. A wrong comparison would flag a legal window or cut a short one.
- **Starts and stops at the wrong time.** Stops are sent while idle and extra starts while integrating. A design that does not gate these would open phantom windows or restart an open one.
- **Overlap and overrun.** A new frame is started during a readout, and one is closed while a readout is still running. A design that blocks starts during readout would miss the overlap. One that queues the extra close would emit a readout that should not exist.

// File: rtl/exp_timing_pkg.sv
package exp_timing_pkg;
  localparam int NUM_TRIG   = 2;
  localparam int TRIG_START = 0;
  localparam int TRIG_STOP  = 1;
endpackage

// File: rtl/trig_qualify.sv
module trig_qualify #(
  parameter int MIN_PULSE = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic accept_o,
  output logic short_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          s1_q, s2_q, done_q;
  logic [CW-1:0] cnt_q;

  // first stage on the falling edge keeps shared-clock controllers aligned
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= 1'b0;
    else         s1_q <= trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_q     <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      accept_o <= 1'b0;
      short_o  <= 1'b0;
    end else begin
      s2_q     <= s1_q;
      accept_o <= 1'b0;
      short_o  <= 1'b0;
      if (s2_q) begin
        if (!done_q) begin
          if (cnt_q == CW'(MIN_PULSE - 1)) begin
            accept_o <= 1'b1;
            done_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      end else begin
        if (cnt_q != '0 && !done_q) short_o <= 1'b1;
        cnt_q  <= '0;
        done_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exp_window.sv
module exp_window #(
  parameter int START_DLY = 10,
  parameter int STOP_DLY  = 130,
  parameter int MIN_EXP   = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_acc_i,
  input  logic stop_acc_i,
  output logic integ_o,
  output logic close_o,
  output logic err_min_o
);
  localparam int SW = $clog2(START_DLY + 1);
  localparam int TW = $clog2(STOP_DLY + 1);
  localparam int EW = $clog2(MIN_EXP + 1);

  logic          start_pend_q, stop_pend_q, stop_late_q;
  logic [SW-1:0] scnt_q;
  logic [TW-1:0] tcnt_q;
  logic [EW-1:0] ecnt_q;
  logic          exp_ok;

  assign exp_ok = (ecnt_q == EW'(MIN_EXP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      stop_late_q  <= 1'b0;
      scnt_q       <= '0;
      tcnt_q       <= '0;
      ecnt_q       <= '0;
      integ_o      <= 1'b0;
      close_o      <= 1'b0;
      err_min_o    <= 1'b0;
    end else begin
      close_o   <= 1'b0;
      err_min_o <= 1'b0;
      // opening path
      if (start_pend_q) begin
        if (scnt_q == SW'(START_DLY - 1)) begin
          integ_o      <= 1'b1;
          start_pend_q <= 1'b0;
          ecnt_q       <= '0;
        end else begin
          scnt_q <= scnt_q + SW'(1);
        end
      end else if (start_acc_i && !integ_o) begin
        start_pend_q <= 1'b1;
        scnt_q       <= '0;
      end
      // closing path, only while a window is open
      if (integ_o) begin
        if (!exp_ok) ecnt_q <= ecnt_q + EW'(1);
        if (stop_pend_q) begin
          if (tcnt_q == TW'(STOP_DLY - 1)) begin
            if (exp_ok) begin
              integ_o     <= 1'b0;
              close_o     <= 1'b1;
              stop_pend_q <= 1'b0;
              stop_late_q <= 1'b0;
            end else if (!stop_late_q) begin
              stop_late_q <= 1'b1;
              err_min_o   <= 1'b1;
            end
          end else begin
            tcnt_q <= tcnt_q + TW'(1);
          end
        end else if (stop_acc_i) begin
          stop_pend_q <= 1'b1;
          tcnt_q      <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq #(
  parameter int RO_DLY = 100,
  parameter int RO_LEN = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic close_i,
  output logic ro_start_o,
  output logic ro_active_o,
  output logic overrun_o
);
  localparam int RW = $clog2(RO_DLY + 1);
  localparam int AW = $clog2(RO_LEN + 1);

  logic          pend_q;
  logic [RW-1:0] rcnt_q;
  logic [AW-1:0] acnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      rcnt_q      <= '0;
      acnt_q      <= '0;
      ro_start_o  <= 1'b0;
      ro_active_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      ro_start_o <= 1'b0;
      overrun_o  <= 1'b0;
      if (close_i) begin
        if (pend_q || ro_active_o) begin
          overrun_o <= 1'b1;
        end else begin
          pend_q <= 1'b1;
          rcnt_q <= RW'(1);  // close_i lags the window edge by one cycle
        end
      end
      if (pend_q) begin
        if (rcnt_q == RW'(RO_DLY - 1)) begin
          pend_q      <= 1'b0;
          ro_start_o  <= 1'b1;
          ro_active_o <= 1'b1;
          acnt_q      <= '0;
        end else begin
          rcnt_q <= rcnt_q + RW'(1);
        end
      end
      if (ro_active_o) begin
        if (acnt_q == AW'(RO_LEN - 1)) ro_active_o <= 1'b0;
        else                           acnt_q <= acnt_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/exposure_timing_ctrl.sv
module exposure_timing_ctrl
  import exp_timing_pkg::*;
#(
  parameter int MIN_PULSE = 100,
  parameter int START_DLY = 10,
  parameter int STOP_DLY  = 130,
  parameter int MIN_EXP   = 500,
  parameter int RO_DLY    = 100,
  parameter int RO_LEN    = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_start_i,
  input  logic trig_stop_i,
  output logic integrate_o,
  output logic ro_start_o,
  output logic ro_active_o,
  output logic err_short_start_o,
  output logic err_short_stop_o,
  output logic err_min_exp_o,
  output logic err_overrun_o
);
  logic [NUM_TRIG-1:0] trig_raw, trig_acc, trig_short;
  logic                win_close;

  always_comb begin
    trig_raw             = '0;
    trig_raw[TRIG_START] = trig_start_i;
    trig_raw[TRIG_STOP]  = trig_stop_i;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_qual
    trig_qualify #(.MIN_PULSE(MIN_PULSE)) u_qual (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .trig_i   (trig_raw[g]),
      .accept_o (trig_acc[g]),
      .short_o  (trig_short[g])
    );
  end

  exp_window #(
    .START_DLY (START_DLY),
    .STOP_DLY  (STOP_DLY),
    .MIN_EXP   (MIN_EXP)
  ) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_acc_i (trig_acc[TRIG_START]),
    .stop_acc_i  (trig_acc[TRIG_STOP]),
    .integ_o     (integrate_o),
    .close_o     (win_close),
    .err_min_o   (err_min_exp_o)
  );

  readout_seq #(
    .RO_DLY (RO_DLY),
    .RO_LEN (RO_LEN)
  ) u_ro (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .close_i     (win_close),
    .ro_start_o  (ro_start_o),
    .ro_active_o (ro_active_o),
    .overrun_o   (err_overrun_o)
  );

  assign err_short_start_o = trig_short[TRIG_START];
  assign err_short_stop_o  = trig_short[TRIG_STOP];
endmodule

// File: rtl/exp_timing_chk.sv
module exp_timing_chk #(
  parameter int MIN_EXP = 500,
  parameter int RO_LEN  = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic integrate_i,
  input logic ro_start_i,
  input logic ro_active_i,
  input logic err_min_exp_i,
  input logic err_short_start_i
);
  localparam int IW = $clog2(MIN_EXP + 1);
  localparam int AW = $clog2(RO_LEN + 2);

  logic [IW-1:0] ilen_q;
  logic [AW-1:0] alen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ilen_q <= '0;
      alen_q <= '0;
    end else begin
      if (!integrate_i)                   ilen_q <= '0;
      else if (ilen_q != IW'(MIN_EXP))    ilen_q <= ilen_q + IW'(1);
      if (!ro_active_i)                   alen_q <= '0;
      else if (alen_q != AW'(RO_LEN + 1)) alen_q <= alen_q + AW'(1);
    end
  end

  a_r3_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(integrate_i) |-> ilen_q == IW'(MIN_EXP));
  a_r3_err_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_min_exp_i |-> integrate_i);
  a_r4_short_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_short_start_i |=> !err_short_start_i);
  a_r6_start_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_start_i |=> !ro_start_i);
  a_r6_start_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_start_i |-> ro_active_i);
  a_r6_active_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ro_active_i) |-> ro_start_i);
  a_r6_active_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ro_active_i) |-> alen_q == AW'(RO_LEN));
endmodule

bind exposure_timing_ctrl exp_timing_chk #(
  .MIN_EXP (MIN_EXP),
  .RO_LEN  (RO_LEN)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .integrate_i       (integrate_o),
  .ro_start_i        (ro_start_o),
  .ro_active_i       (ro_active_o),
  .err_min_exp_i     (err_min_exp_o),
  .err_short_start_i (err_short_start_o)
);

// File: tb/sim_exposure_timing_ctrl.sv
module sim_exposure_timing_ctrl;
  localparam int MP = 8, SD = 3, STD = 13, ML = 50, RD = 10, RL = 60;

  logic clk = 1'b0, rst_ni = 1'b0, ts = 1'b0, tp = 1'b0;
  logic integ, ros, roa, e_ss, e_sp, e_min, e_ovr;

  exposure_timing_ctrl #(
    .MIN_PULSE(MP), .START_DLY(SD), .STOP_DLY(STD),
    .MIN_EXP(ML), .RO_DLY(RD), .RO_LEN(RL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trig_start_i(ts), .trig_stop_i(tp),
    .integrate_o(integ), .ro_start_o(ros), .ro_active_o(roa),
    .err_short_start_o(e_ss), .err_short_stop_o(e_sp),
    .err_min_exp_o(e_min), .err_overrun_o(e_ovr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rise_cyc, fall_cyc, ros_cyc, roa_fall;
  int n_rise = 0, n_ros = 0, n_ovl = 0, n_ss = 0, n_sp = 0, n_min = 0, n_ovr = 0;
  logic integ_p = 1'b0, roa_p = 1'b0;

  always @(negedge clk) begin
    if (integ && !integ_p) begin rise_cyc = cyc; n_rise++; if (roa) n_ovl++; end
    if (!integ && integ_p) fall_cyc = cyc;
    if (ros) begin ros_cyc = cyc; n_ros++; end
    if (!roa && roa_p) roa_fall = cyc;
    if (e_ss) n_ss++;
    if (e_sp) n_sp++;
    if (e_min) n_min++;
    if (e_ovr) n_ovr++;
    integ_p = integ;
    roa_p   = roa;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic pulse_at(input bit stop, input int w, input int k, output int kr);
    do begin @(posedge clk); #1; end while (cyc < k);
    if (stop) tp = 1'b1; else ts = 1'b1;
    kr = cyc;
    repeat (w) @(posedge clk);
    #1;
    if (stop) tp = 1'b0; else ts = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    do @(negedge clk); while (cyc < n);
    #1;
  endtask

  function automatic int exp_rise(input int k0);
    return k0 + MP + 2 + SD;
  endfunction

  // start already driven at k0; drive stop, check window edges
  task automatic run_frame(input int k0, input int w2, input int gap, output int f);
    int k1, r, nat, m0;
    m0 = n_min;
    pulse_at(1'b1, w2, k0 + SD + 1 + gap, k1);
    r   = exp_rise(k0);
    nat = k1 + MP + 2 + STD;
    f   = (nat < r + ML) ? r + ML : nat;
    wait_cyc(f + 2);
    chk(rise_cyc == r, "R1 start latency", rise_cyc, r);
    chk(fall_cyc == f, (nat < r + ML) ? "R3 held close" : "R2 stop latency", fall_cyc, f);
    chk(n_min - m0 == int'(nat < r + ML), "R3 min exposure flag", n_min - m0, int'(nat < r + ML));
  endtask

  task automatic check_ro(input int s, input int ros0);
    wait_cyc(s + RL + 2);
    chk(ros_cyc == s, "R6 readout start", ros_cyc, s);
    chk(roa_fall == s + RL, "R6 readout length", roa_fall, s + RL);
    chk(n_ros - ros0 == 1, "R6 one readout", n_ros - ros0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k0, k, f, s, r0, ros0, ov0, endc, novl;
    bit have;
    void'($urandom(32'd20240517));

    // R9 reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk({integ, ros, roa, e_ss, e_sp, e_min, e_ovr} == 7'd0, "R9 reset outputs",
        {integ, ros, roa, e_ss, e_sp, e_min, e_ovr}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);

    // R4 short pulses rejected
    pulse_at(1'b0, MP - 1, 0, k);
    wait_cyc(k + MP + 10);
    chk(n_ss == 1, "R4 short start flagged", n_ss, 1);
    chk(n_rise == 0, "R4 short start no window", n_rise, 0);
    pulse_at(1'b1, MP - 1, 0, k);
    wait_cyc(k + MP + 10);
    chk(n_sp == 1, "R4 short stop flagged", n_sp, 1);

    // R5 stop while idle
    pulse_at(1'b1, MP + 5, 0, k);
    wait_cyc(k + MP + STD + 20);
    chk(n_rise == 0 && n_ros == 0 && integ == 1'b0, "R5 idle stop ignored", n_rise + n_ros, 0);
    chk(n_sp + n_min + n_ovr == 1, "R5 idle stop no error", n_sp + n_min + n_ovr, 1);

    // R4 exact-width pulses accepted
    pulse_at(1'b0, MP, 0, k0);
    ros0 = n_ros;
    run_frame(k0, MP, 40, f);
    check_ro(f + RD, ros0);

    // R3 boundary: natural close exactly at MIN_EXP, then one cycle early
    pulse_at(1'b0, MP, 0, k0);
    ros0 = n_ros;
    run_frame(k0, MP, ML - STD - 1, f);
    check_ro(f + RD, ros0);
    pulse_at(1'b0, MP, 0, k0);
    ros0 = n_ros;
    run_frame(k0, MP, ML - STD - 2, f);
    check_ro(f + RD, ros0);

    // R10 second start during an open window
    pulse_at(1'b0, MP, 0, k0);
    r0 = n_rise;
    ros0 = n_ros;
    wait_cyc(exp_rise(k0) + 1);
    pulse_at(1'b0, MP + 2, 0, k);
    run_frame(k0, MP, 30, f);
    check_ro(f + RD, ros0);
    wait_cyc(cyc + MP + SD + 20);
    chk(n_rise - r0 == 1, "R10 extra start ignored", n_rise - r0, 1);

    // random frames, some starting during the previous readout (R7)
    have = 1'b0;
    novl = 0;
    r0 = n_ovl;
    for (int i = 0; i < 25; i++) begin
      if (!have) pulse_at(1'b0, MP + $urandom_range(0, 12), 0, k0);
      run_frame(k0, MP + $urandom_range(0, 12), $urandom_range(0, 70), f);
      s = f + RD;
      ros0 = n_ros;
      have = $urandom_range(0, 1) == 1;
      if (have) begin
        pulse_at(1'b0, MP + $urandom_range(0, 6), 0, k0);
        novl++;
      end
      check_ro(s, ros0);
    end
    if (have) begin
      ros0 = n_ros;
      run_frame(k0, MP, 10, f);
      check_ro(f + RD, ros0);
    end
    chk(n_ovl - r0 == novl, "R7 start during readout", n_ovl - r0, novl);

    // R8 overrun: second window closes during the first readout
    pulse_at(1'b0, MP, 0, k0);
    run_frame(k0, MP, 0, f);
    endc = f + RD + RL;
    ros0 = n_ros;
    ov0  = n_ovr;
    pulse_at(1'b0, MP, 0, k0);
    run_frame(k0, MP, 0, f);
    chk(f < endc, "R8 close inside readout", f, endc);
    wait_cyc(endc + RD + RL + 10);
    chk(n_ovr - ov0 == 1, "R8 overrun flagged", n_ovr - ov0, 1);
    chk(n_ros - ros0 == 1, "R8 dropped readout", n_ros - ros0, 1);

    // R9 reset during an open window
    pulse_at(1'b0, MP, 0, k0);
    wait_cyc(exp_rise(k0) + 5);
    chk(integ == 1'b1, "R1 window open before reset", integ, 1);
    @(posedge clk); #1 rst_ni = 1'b0;
    #1;
    chk({integ, ros, roa, e_ss, e_sp, e_min, e_ovr} == 7'd0, "R9 reset mid-run",
        {integ, ros, roa, e_ss, e_sp, e_min, e_ovr}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (5) @(posedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule